// File: doc/BRIEF.md
# Stack-Relative Effective Address Unit

This unit sits in the address path of an 8-bit accumulator-style CPU with a 16-bit address space. When the decoder starts an operation, the unit captures the stack pointer, the Y index, the address of the next instruction and the two operand bytes. It then produces one of the following:

- a stack-relative data address;
- a pointer fetched from the stack and indexed by Y;
- a PC-relative target for branches and branch-to-subroutine;
- a 16-bit word pushed to, or pulled from, the hardware stack.

The stack occupies one fixed page of memory, and all stack arithmetic wraps inside that page. A small sequencer issues single-byte memory reads and writes. The memory returns read data one cycle after the request. Each operation ends with a one-cycle `done` strobe that carries the result, the updated stack pointer when it changed, and a flag that tells the fetch logic to load the result as the new program counter.

Operations are selected by a 3-bit mode code. The decoder holds `start` high for one cycle with the operands valid. While `busy` is high, any further `start` is ignored.

Top module: `sr_ea_unit`

## Requirements
- R1: While reset is low and in the idle state that follows it, `done`, `mem_rd`, `mem_wr`, `pc_load`, `sp_upd` and `busy` are all 0.
- R2: Mode 0 (stack direct) gives `result` = {0x01, S+off[7:0]}, where the low byte wraps within page 1. `done` rises in the first cycle after the start edge, and `pc_load` and `sp_upd` stay 0.
- R3: Mode 1 (stack indirect, Y-indexed) works as follows:
  - It reads the pointer low byte at {0x01, S+off} in the first cycle after the start edge.
  - It reads the high byte at {0x01, S+off+1} in the second cycle, with the offset wrapping in page 1.
  - In the fourth cycle `done` gives the 16-bit pointer plus Y, with carry into the high byte.
- R4: Mode 2 (jump through stack pointer, Y-indexed) uses the same reads, timing and result as mode 1 and asserts `pc_load` together with `done`.
- R5: Mode 3 (relative 16-bit target) gives `result` = next-instruction address + {op_hi, op_lo} modulo 2^16, with `pc_load` high. `done` rises in the first cycle after the start edge.
- R6: Mode 4 (push immediate word) works as follows:
  - It writes op_hi at {0x01, S} and then op_lo at {0x01, S-1} in consecutive cycles, with the address wrapping in page 1.
  - In the third cycle `done` reports `sp_out` = S-2 with `sp_upd` high and `result` equal to the pushed word.
- R7: Mode 5 (push relative address) pushes next-instruction address + rel16. The write order and timing are the same as in R6.
- R8: Mode 6 (push word from zero page) works as follows:
  - It reads the low byte at {0x00, zp} and the high byte at {0x00, zp+1}, with zp+1 wrapping within page 0.
  - It then pushes that word as in R6.
  - `done` comes in the sixth cycle.
- R9: Mode 7 (pull word) reads the low byte at {0x01, S+1} and the high byte at {0x01, S+2}, both wrapping in page 1. In the fourth cycle `done` gives the word in `result` and `sp_out` = S+2 with `sp_upd` high.
- R10: A `start` asserted while `busy` is high is ignored: the running operation completes with its own result and only one `done` pulse.
- R11: `mem_rd` and `mem_wr` are never high together, and `done` is high for exactly one cycle per accepted operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (accepted when not busy) |
| mode | input | 3 | Operation code (0 to 7, see requirements) |
| sp_in | input | 8 | Stack pointer at start |
| y_in | input | 8 | Y index at start |
| npc | input | 16 | Address of the following instruction |
| opnd | input | 16 | Operand bytes: offset or zp in [7:0], high byte in [15:8] |
| mem_rdata | input | 8 | Read data, valid the cycle after a read request |
| busy | output | 1 | Operation in progress |
| mem_rd | output | 1 | Read request |
| mem_wr | output | 1 | Write request |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Write data |
| done | output | 1 | Result valid strobe |
| result | output | 16 | Effective address, branch target, or word moved |
| pc_load | output | 1 | Load result into the program counter |
| sp_out | output | 8 | Updated stack pointer |
| sp_upd | output | 1 | `sp_out` is to be written back |

## Verification
The bench builds the unit with its defaults: a 16-bit address, 8-bit data and the stack in page 1. With these values the wrap points can be reached with small operands, including S+off rolling from 0xFF to 0x00, S-1 from 0x00 to 0xFF, zp+1 from 0xFF to 0x00, and 16-bit PC-relative sums overflowing. The memory model returns a byte computed from the address. This makes the order of the pointer bytes, the carry from Y into the high byte, and every request address visible in the results.

// File: rtl/sr_ea_pkg.sv
// Package: shared mode codes and sequencer states for the stack-relative
// effective address unit. Assumes a 3-bit mode field from the decoder.
package sr_ea_pkg;

    typedef enum logic [2:0] {
        M_SR   = 3'd0,   // stack direct
        M_SRIY = 3'd1,   // stack indirect, Y-indexed
        M_JSIY = 3'd2,   // jump through stack pointer, Y-indexed
        M_REL  = 3'd3,   // PC-relative 16-bit target
        M_PSHI = 3'd4,   // push immediate word
        M_PSHR = 3'd5,   // push PC-relative address
        M_PSHZ = 3'd6,   // push word read from zero page
        M_PULL = 3'd7    // pull word
    } ea_mode_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_LO,
        S_RD_HI,
        S_RD_END,
        S_WR_HI,
        S_WR_LO,
        S_DONE
    } ea_state_e;

endpackage

// File: rtl/sr_ea_addr.sv
// Address arithmetic: every sum the unit can present, computed in parallel
// from the captured operands. Purely combinational; assumes AW = 2 * DW
// and stack and zero-page arithmetic wrap inside their page.
module sr_ea_addr #(
    parameter int AW = 16,
    parameter logic [AW/2-1:0] STACK_PAGE = 8'h01
) (
    input  logic [AW/2-1:0] sp_q,
    input  logic [AW/2-1:0] y_q,
    input  logic [AW-1:0]   npc_q,
    input  logic [AW-1:0]   opnd_q,
    input  logic [AW-1:0]   word_q,
    output logic [AW-1:0]   sr_addr,
    output logic [AW-1:0]   sr_addr1,
    output logic [AW-1:0]   zp_addr0,
    output logic [AW-1:0]   zp_addr1,
    output logic [AW-1:0]   pl_addr1,
    output logic [AW-1:0]   pl_addr2,
    output logic [AW-1:0]   push_addr,
    output logic [AW-1:0]   rel_sum,
    output logic [AW-1:0]   idx_sum
);
    localparam int DW = AW / 2;
    localparam logic [DW-1:0] ONE  = 1;
    localparam logic [DW-1:0] TWO  = 2;
    localparam logic [DW-1:0] ZERO = '0;

    logic [DW-1:0] off, sr_lo, sr_lo1, zp1, pl1, pl2;

    // Page-local low bytes, each wrapping at the page boundary
    always_comb begin
        off    = opnd_q[DW-1:0];
        sr_lo  = sp_q + off;
        sr_lo1 = sr_lo + ONE;
        zp1    = off + ONE;
        pl1    = sp_q + ONE;
        pl2    = sp_q + TWO;
    end

    // Full addresses and the two 16-bit sums
    always_comb begin
        sr_addr   = {STACK_PAGE, sr_lo};
        sr_addr1  = {STACK_PAGE, sr_lo1};
        zp_addr0  = {ZERO, off};
        zp_addr1  = {ZERO, zp1};
        pl_addr1  = {STACK_PAGE, pl1};
        pl_addr2  = {STACK_PAGE, pl2};
        push_addr = {STACK_PAGE, sp_q};
        rel_sum   = npc_q + opnd_q;
        idx_sum   = word_q + {ZERO, y_q};
    end

endmodule

// File: rtl/sr_ea_seq.sv
// Sequencer: captures operands on an accepted start and steps through the
// byte reads and writes an operation needs, then strobes done for one cycle.
// Assumes memory read data arrives one cycle after the read request.
module sr_ea_seq
    import sr_ea_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [2:0]      mode_in,
    input  logic [AW/2-1:0] sp_in,
    input  logic [AW/2-1:0] y_in,
    input  logic [AW-1:0]   npc_in,
    input  logic [AW-1:0]   opnd_in,
    input  logic [AW/2-1:0] mem_rdata,
    input  logic [AW-1:0]   sr_addr,
    input  logic [AW-1:0]   sr_addr1,
    input  logic [AW-1:0]   zp_addr0,
    input  logic [AW-1:0]   zp_addr1,
    input  logic [AW-1:0]   pl_addr1,
    input  logic [AW-1:0]   pl_addr2,
    input  logic [AW-1:0]   push_addr,
    input  logic [AW-1:0]   rel_sum,
    input  logic [AW-1:0]   idx_sum,
    output logic [AW/2-1:0] sp_q,
    output logic [AW/2-1:0] y_q,
    output logic [AW-1:0]   npc_q,
    output logic [AW-1:0]   opnd_q,
    output logic [AW-1:0]   word_q,
    output logic            busy,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic [AW-1:0]   mem_addr,
    output logic [AW/2-1:0] mem_wdata,
    output logic            done,
    output logic [AW-1:0]   result,
    output logic            pc_load,
    output logic [AW/2-1:0] sp_out,
    output logic            sp_upd
);
    localparam int DW = AW / 2;
    localparam logic [DW-1:0] ONE = 1;
    localparam logic [DW-1:0] TWO = 2;

    ea_state_e state;
    ea_mode_e  mode_q;
    logic [AW-1:0] push_word;
    logic is_push, is_pull, is_read;

    // Mode classes used by the transitions and the output muxes
    always_comb begin
        is_push = (mode_q == M_PSHI) || (mode_q == M_PSHR) || (mode_q == M_PSHZ);
        is_pull = (mode_q == M_PULL);
        is_read = (mode_q == M_SRIY) || (mode_q == M_JSIY) || is_pull || (mode_q == M_PSHZ);
    end

    // Source of the word being pushed
    always_comb begin
        case (mode_q)
            M_PSHI:  push_word = opnd_q;
            M_PSHR:  push_word = rel_sum;
            default: push_word = word_q;
        endcase
    end

    // State register, operand capture, pointer assembly and stack pointer update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            mode_q <= M_SR;
            sp_q   <= '0;
            y_q    <= '0;
            npc_q  <= '0;
            opnd_q <= '0;
            word_q <= '0;
        end else begin
            case (state)
                S_IDLE: if (start) begin
                    mode_q <= ea_mode_e'(mode_in);
                    sp_q   <= sp_in;
                    y_q    <= y_in;
                    npc_q  <= npc_in;
                    opnd_q <= opnd_in;
                    case (ea_mode_e'(mode_in))
                        M_SR, M_REL:    state <= S_DONE;
                        M_PSHI, M_PSHR: state <= S_WR_HI;
                        default:        state <= S_RD_LO;
                    endcase
                end
                S_RD_LO: state <= S_RD_HI;
                S_RD_HI: begin
                    word_q[DW-1:0] <= mem_rdata;
                    state          <= S_RD_END;
                end
                S_RD_END: begin
                    word_q[AW-1:DW] <= mem_rdata;
                    if (is_pull) sp_q <= sp_q + TWO;
                    state <= is_push ? S_WR_HI : S_DONE;
                end
                S_WR_HI: begin
                    sp_q  <= sp_q - ONE;
                    state <= S_WR_LO;
                end
                S_WR_LO: begin
                    sp_q  <= sp_q - ONE;
                    state <= S_DONE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Memory request drive for each state
    always_comb begin
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (state)
            S_RD_LO: begin
                mem_rd   = is_read;
                mem_addr = is_pull ? pl_addr1 : (mode_q == M_PSHZ) ? zp_addr0 : sr_addr;
            end
            S_RD_HI: begin
                mem_rd   = is_read;
                mem_addr = is_pull ? pl_addr2 : (mode_q == M_PSHZ) ? zp_addr1 : sr_addr1;
            end
            S_WR_HI: begin
                mem_wr    = 1'b1;
                mem_addr  = push_addr;
                mem_wdata = push_word[AW-1:DW];
            end
            S_WR_LO: begin
                mem_wr    = 1'b1;
                mem_addr  = push_addr;
                mem_wdata = push_word[DW-1:0];
            end
            default: ;
        endcase
    end

    // Completion outputs and result selection
    always_comb begin
        busy    = (state != S_IDLE);
        done    = (state == S_DONE);
        pc_load = done && ((mode_q == M_REL) || (mode_q == M_JSIY));
        sp_upd  = done && (is_push || is_pull);
        sp_out  = sp_q;
        case (mode_q)
            M_SR:           result = sr_addr;
            M_SRIY, M_JSIY: result = idx_sum;
            M_REL:          result = rel_sum;
            M_PULL:         result = word_q;
            default:        result = push_word;
        endcase
    end

endmodule

// File: rtl/sr_ea_unit.sv
// Top: stack-relative effective address unit. Joins the address arithmetic
// to the sequencer. Assumes a single-byte memory port with one-cycle read latency.
module sr_ea_unit #(
    parameter int AW = 16,
    parameter logic [AW/2-1:0] STACK_PAGE = 8'h01
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [2:0]      mode,
    input  logic [AW/2-1:0] sp_in,
    input  logic [AW/2-1:0] y_in,
    input  logic [AW-1:0]   npc,
    input  logic [AW-1:0]   opnd,
    input  logic [AW/2-1:0] mem_rdata,
    output logic            busy,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic [AW-1:0]   mem_addr,
    output logic [AW/2-1:0] mem_wdata,
    output logic            done,
    output logic [AW-1:0]   result,
    output logic            pc_load,
    output logic [AW/2-1:0] sp_out,
    output logic            sp_upd
);
    localparam int DW = AW / 2;

    logic [DW-1:0] sp_q, y_q;
    logic [AW-1:0] npc_q, opnd_q, word_q;
    logic [AW-1:0] sr_addr, sr_addr1, zp_addr0, zp_addr1;
    logic [AW-1:0] pl_addr1, pl_addr2, push_addr, rel_sum, idx_sum;

    sr_ea_addr #(.AW(AW), .STACK_PAGE(STACK_PAGE)) u_addr (
        .sp_q(sp_q), .y_q(y_q), .npc_q(npc_q), .opnd_q(opnd_q), .word_q(word_q),
        .sr_addr(sr_addr), .sr_addr1(sr_addr1), .zp_addr0(zp_addr0),
        .zp_addr1(zp_addr1), .pl_addr1(pl_addr1), .pl_addr2(pl_addr2),
        .push_addr(push_addr), .rel_sum(rel_sum), .idx_sum(idx_sum)
    );

    sr_ea_seq #(.AW(AW)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_in(mode),
        .sp_in(sp_in), .y_in(y_in), .npc_in(npc), .opnd_in(opnd),
        .mem_rdata(mem_rdata),
        .sr_addr(sr_addr), .sr_addr1(sr_addr1), .zp_addr0(zp_addr0),
        .zp_addr1(zp_addr1), .pl_addr1(pl_addr1), .pl_addr2(pl_addr2),
        .push_addr(push_addr), .rel_sum(rel_sum), .idx_sum(idx_sum),
        .sp_q(sp_q), .y_q(y_q), .npc_q(npc_q), .opnd_q(opnd_q), .word_q(word_q),
        .busy(busy), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .done(done), .result(result), .pc_load(pc_load),
        .sp_out(sp_out), .sp_upd(sp_upd)
    );

endmodule

// File: rtl/sr_ea_unit_chk.sv
// Checker: port-level temporal properties of the address unit, attached
// by bind. Assumes start is honoured only when busy is low.
module sr_ea_unit_chk #(
    parameter int AW = 16,
    parameter logic [AW/2-1:0] STACK_PAGE = 8'h01
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic [2:0]      mode,
    input logic [AW/2-1:0] sp_in,
    input logic [AW/2-1:0] y_in,
    input logic [AW-1:0]   npc,
    input logic [AW-1:0]   opnd,
    input logic [AW/2-1:0] mem_rdata,
    input logic            busy,
    input logic            mem_rd,
    input logic            mem_wr,
    input logic [AW-1:0]   mem_addr,
    input logic [AW/2-1:0] mem_wdata,
    input logic            done,
    input logic [AW-1:0]   result,
    input logic            pc_load,
    input logic [AW/2-1:0] sp_out,
    input logic            sp_upd
);
    localparam int DW = AW / 2;
    logic [DW-1:0] exp_sr_lo;
    logic [AW-1:0] exp_rel;
    logic          take;

    // Expected values formed from the inputs at the start cycle
    always_comb begin
        exp_sr_lo = sp_in + opnd[DW-1:0];
        exp_rel   = npc + opnd;
        take      = start && !busy;
    end

    assert_rdwr_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_rd && !mem_wr && !done));

    assert_direct_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (take && mode == 3'd0) |=> (done && !pc_load && result == {STACK_PAGE, $past(exp_sr_lo)}));

    assert_rel_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (take && mode == 3'd3) |=> (done && pc_load && result == $past(exp_rel)));

    assert_push_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (take && mode == 3'd4) |=> (mem_wr && mem_addr == {STACK_PAGE, $past(sp_in)}
                                     && mem_wdata == $past(opnd[AW-1:DW])));

    assert_pcload_only_on_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_load || sp_upd) |-> done);

endmodule

bind sr_ea_unit sr_ea_unit_chk #(.AW(AW), .STACK_PAGE(STACK_PAGE)) u_chk (.*);

// File: tb/sr_ea_unit_tb.sv
// Bench: vector table walked by one loop, then directed reset and busy tests.
module sr_ea_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  mode = '0;
    logic [7:0]  sp_in = '0, y_in = '0;
    logic [15:0] npc = '0, opnd = '0;
    logic [7:0]  mem_rdata = '0;
    logic        busy, mem_rd, mem_wr, done, pc_load, sp_upd;
    logic [15:0] mem_addr, result;
    logic [7:0]  mem_wdata, sp_out;

    int checks = 0;
    int errors = 0;

    sr_ea_unit u_dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    // Memory model: each byte is a fixed function of its address
    function automatic logic [7:0] mb(input logic [15:0] a);
        return (a[7:0] * 8'd7) ^ a[15:8] ^ 8'h3C;
    endfunction

    always_ff @(posedge clk) if (mem_rd) mem_rdata <= mb(mem_addr);

    // Vector fields: mode, sp, y, npc, opnd
    localparam logic [50:0] VEC [NV] = '{
        {3'd0, 8'h40, 8'h00, 16'h0000, 16'h0003},
        {3'd0, 8'hFF, 8'h00, 16'h0000, 16'h0001},
        {3'd1, 8'h80, 8'h10, 16'h0000, 16'h0005},
        {3'd1, 8'hFE, 8'hFF, 16'h0000, 16'h0001},
        {3'd2, 8'h20, 8'h05, 16'h0000, 16'h0002},
        {3'd3, 8'h00, 8'h00, 16'h1234, 16'h0100},
        {3'd3, 8'h00, 8'h00, 16'hFFF0, 16'h0020},
        {3'd4, 8'h00, 8'h00, 16'h0000, 16'hBEEF},
        {3'd5, 8'h80, 8'h00, 16'h2000, 16'hFFFE},
        {3'd6, 8'h50, 8'h00, 16'h0000, 16'h00FF},
        {3'd7, 8'hFF, 8'h00, 16'h0000, 16'h0000},
        {3'd7, 8'h30, 8'h00, 16'h0000, 16'h0000}
    };

    int          lat, nw, nr;
    logic [15:0] r_res;
    logic        r_pcl, r_spu, r_after, r_ovl;
    logic [7:0]  r_sp;
    logic [15:0] wa [4];
    logic [7:0]  wd [4];
    logic [15:0] ra [4];

    task automatic chk(input logic ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic run_op(input logic [2:0] m, input logic [7:0] s, input logic [7:0] y,
                          input logic [15:0] pc, input logic [15:0] op);
        @(negedge clk);
        start = 1'b1; mode = m; sp_in = s; y_in = y; npc = pc; opnd = op;
        @(negedge clk);
        start = 1'b0;
        lat = 0; nw = 0; nr = 0; r_ovl = 1'b0;
        for (int c = 1; c <= 12; c++) begin
            if (mem_rd && mem_wr) r_ovl = 1'b1;
            if (mem_wr && nw < 4) begin wa[nw] = mem_addr; wd[nw] = mem_wdata; nw++; end
            if (mem_rd && nr < 4) begin ra[nr] = mem_addr; nr++; end
            if (done) begin
                lat = c; r_res = result; r_pcl = pc_load; r_spu = sp_upd; r_sp = sp_out;
                break;
            end
            @(negedge clk);
        end
        @(negedge clk);
        r_after = done;
    endtask

    function automatic string tag_of(input logic [2:0] m);
        case (m)
            3'd0: return "R2";  3'd1: return "R3";  3'd2: return "R4";  3'd3: return "R5";
            3'd4: return "R6";  3'd5: return "R7";  3'd6: return "R8";  default: return "R9";
        endcase
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [2:0] m; logic [7:0] s, y, lo8, hi8; logic [15:0] pc, op, exp, wexp;
        int elat; int npulse;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(!done && !mem_rd && !mem_wr && !busy && !pc_load && !sp_upd, "R1", "outputs in reset",
            {26'd0, done, mem_rd, mem_wr, busy, pc_load, sp_upd}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !mem_rd && !mem_wr && !busy, "R1", "outputs idle after reset",
            {28'd0, done, mem_rd, mem_wr, busy}, 0);

        for (int i = 0; i < NV; i++) begin
            {m, s, y, pc, op} = VEC[i];
            run_op(m, s, y, pc, op);
            case (m)
                3'd0: begin exp = {8'h01, 8'(s + op[7:0])}; elat = 1; end
                3'd1, 3'd2: begin
                    lo8 = mb({8'h01, 8'(s + op[7:0])});
                    hi8 = mb({8'h01, 8'(s + op[7:0] + 8'd1)});
                    exp = {hi8, lo8} + {8'h00, y}; elat = 4;
                end
                3'd3: begin exp = pc + op; elat = 1; end
                3'd4: begin exp = op; elat = 3; end
                3'd5: begin exp = pc + op; elat = 3; end
                3'd6: begin
                    exp = {mb({8'h00, 8'(op[7:0] + 8'd1)}), mb({8'h00, op[7:0]})}; elat = 6;
                end
                default: begin
                    exp = {mb({8'h01, 8'(s + 8'd2)}), mb({8'h01, 8'(s + 8'd1)})}; elat = 4;
                end
            endcase
            chk(r_res == exp, tag_of(m), $sformatf("result vec %0d", i), r_res, exp);
            chk(lat == elat, tag_of(m), $sformatf("latency vec %0d", i), lat, elat);
            chk(r_pcl == (m == 3'd3 || m == 3'd2), tag_of(m), "pc_load", r_pcl, (m == 3'd3 || m == 3'd2));
            chk(!r_after && !r_ovl, "R11", "single done pulse, no rd/wr overlap", {r_after, r_ovl}, 0);
            if (m >= 3'd4) begin
                wexp = (m == 3'd7) ? {8'h00, 8'(s + 8'd2)} : {8'h00, 8'(s - 8'd2)};
                chk(r_spu && r_sp == wexp[7:0], tag_of(m), "new stack pointer", r_sp, wexp[7:0]);
            end else
                chk(!r_spu, tag_of(m), "no sp update", r_spu, 0);
            if (m >= 3'd4 && m <= 3'd6) begin
                chk(nw == 2, tag_of(m), "write count", nw, 2);
                chk(wa[0] == {8'h01, s} && wd[0] == exp[15:8], tag_of(m), "high byte write",
                    {wa[0], wd[0]}, {8'h01, s, exp[15:8]});
                chk(wa[1] == {8'h01, 8'(s - 8'd1)} && wd[1] == exp[7:0], tag_of(m), "low byte write",
                    {wa[1], wd[1]}, {8'h01, 8'(s - 8'd1), exp[7:0]});
            end
            if (m == 3'd1 || m == 3'd2) begin
                chk(ra[0] == {8'h01, 8'(s + op[7:0])} && ra[1] == {8'h01, 8'(s + op[7:0] + 8'd1)},
                    tag_of(m), "pointer read addresses", {ra[0], ra[1]},
                    {8'h01, 8'(s + op[7:0]), 8'h01, 8'(s + op[7:0] + 8'd1)});
            end
            if (m == 3'd6)
                chk(ra[0] == {8'h00, op[7:0]} && ra[1] == {8'h00, 8'(op[7:0] + 8'd1)}, "R8",
                    "zero page reads", {ra[0], ra[1]}, {8'h00, op[7:0], 8'h00, 8'(op[7:0] + 8'd1)});
            if (m == 3'd7)
                chk(ra[0] == {8'h01, 8'(s + 8'd1)} && ra[1] == {8'h01, 8'(s + 8'd2)}, "R9",
                    "pull read addresses", {ra[0], ra[1]}, {8'h01, 8'(s + 8'd1), 8'h01, 8'(s + 8'd2)});
        end

        // R10: start while busy is ignored
        @(negedge clk);
        start = 1'b1; mode = 3'd1; sp_in = 8'h10; y_in = 8'h01; npc = 16'h0; opnd = 16'h0002;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        start = 1'b1; mode = 3'd0; sp_in = 8'h99; opnd = 16'h0044;
        @(negedge clk);
        start = 1'b0;
        npulse = 0; r_res = '0;
        for (int c = 3; c <= 9; c++) begin
            if (done) begin npulse++; r_res = result; end
            @(negedge clk);
        end
        exp = {mb(16'h0113), mb(16'h0112)} + 16'h0001;
        chk(npulse == 1, "R10", "done pulses during busy start", npulse, 1);
        chk(r_res == exp, "R10", "result of running op kept", r_res, exp);

        // R1: reset in the middle of a push
        @(negedge clk);
        start = 1'b1; mode = 3'd4; sp_in = 8'h40; opnd = 16'h1234;
        @(negedge clk);
        start = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        chk(!done && !mem_wr && !mem_rd && !busy, "R1", "abort by reset",
            {28'd0, done, mem_wr, mem_rd, busy}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule